// File: doc/BRIEF.md
# Ordered Four-Rail Power Sequencer

This controller brings up four supply rails, named A, B, C and D, in a fixed order and takes them down in the reverse order. Before a start is allowed, every rail-good input, the active-low enable and the shared kill line must all be satisfied without a break for a lockout interval. Each later rail is switched on as soon as the rail before it reports that it is nearly at full level. No timed delay is used between steps. The system reset output is held low until a hold interval has passed after rail D reports full.

A loss of any rail-good input is treated as a fault. On a fault, all gate drives drop together and the reset output goes low. If the fault lasts longer than a filter interval, the controller also pulls the shared kill line low, so that other sequencers on the same wire shut down too. The kill line is modelled as a sensed input plus an open-drain style output. A low level on that input forces every gate off. A rising edge on it, while every other condition is already met, starts the turn-on sequence at once without waiting for the lockout. After a fault clears, turn-on restarts by itself once the conditions have again held for the lockout interval.

The gate drive circuitry lies outside this block. Each rail reports its state through three flags: near-full, full and low. The lockout, reset-hold and fault-filter intervals are counted in clock cycles.

Top module: `rail_seq_top`

## Requirements
- R1: Rail A's gate (gate_on bit 0) turns on at the (LOCKOUT_CYC+1)th rising edge after the qualifying condition becomes true. The condition is: uv_ok all ones, en_n low and sys_kill_in high. If any part of the condition drops, the count starts again from zero.
- R2: gate_on only ever takes the values 0000, 0001, 0011, 0111 and 1111, with bit 0 for A and bit 3 for D. Gate k (k > 0) turns on only on an edge at which near_full[k-1] was sampled high, so turn-on runs in the order A, B, C, D.
- R3: rst_out_n goes high at the (HOLD_CYC+1)th rising edge after the edge at which full[3] is first sampled high during turn-on. rst_out_n is high only while all four gates are on.
- R4: On the edge after any uv_ok bit is sampled low, all gates are off and rst_out_n is low.
- R5: sys_kill_out_n goes low only after FILT_CYC consecutive edges have sampled a uv_ok bit low. A shorter fault leaves it high. It returns high on the edge after all uv_ok bits are sampled high again.
- R6: On the edge after sys_kill_in is sampled low, all gates are off and rst_out_n is low.
- R7: A rising edge on sys_kill_in that is sampled while uv_ok is all ones and en_n is low turns on gate A at that same edge, without waiting for the lockout. A rising edge while en_n is high starts nothing.
- R8: On the edge after en_n is sampled high, gate D turns off and rst_out_n goes low. Each following gate (C, then B, then A) turns off only on an edge at which low_flag of the gate above it was sampled high.
- R9: After a fault clears, the turn-on sequence restarts without any other action, following the timing in R1.
- R10: While rst_n is low, and on leaving reset, gate_on is 0000, rst_out_n is low and sys_kill_out_n is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uv_ok | input | 4 | Rail-good inputs, bit 0 = A; 1 means satisfied |
| en_n | input | 1 | Active-low enable; high requests turn-off |
| sys_kill_in | input | 1 | Sensed level of the shared kill line; low forces all gates off |
| near_full | input | 4 | Rail gate is near full level |
| full | input | 4 | Rail gate is fully on |
| low_flag | input | 4 | Rail gate is below the off threshold |
| gate_on | output | 4 | Gate drive requests, bit 0 = A |
| rst_out_n | output | 1 | System reset, active low |
| sys_kill_out_n | output | 1 | Pull-down request for the shared kill line (0 = pull low) |

## Verification
The step assertions assume that the status flags come from a plausible gate: near-full and full appear only on a gate that is driven on, and low appears on a gate that is off and has drained. In the bench, a rail level model ramps up and down at one step per cycle and derives the three flags from that level, so the flags always follow the gate requests. The bench drives the kill line input separately from the kill output, as an external driver of the shared wire would. It changes every input away from the sampling edge, so each interval can be counted to the exact edge.

// File: rtl/rail_seq_pkg.sv
package rail_seq_pkg;
  localparam int RAILS = 4;
  localparam int IDX_W = $clog2(RAILS);

  typedef logic [RAILS-1:0] rail_vec_t;
  typedef logic [IDX_W-1:0] rail_idx_t;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_RAMP_UP,
    ST_WAIT_FULL,
    ST_HOLD,
    ST_RUN,
    ST_RAMP_DN
  } seq_state_e;

  localparam rail_idx_t IDX_FIRST = rail_idx_t'(0);
  localparam rail_idx_t IDX_LAST  = rail_idx_t'(RAILS - 1);

  function automatic rail_idx_t idx_up(input rail_idx_t i);
    return i + 1'b1;
  endfunction

  function automatic rail_idx_t idx_dn(input rail_idx_t i);
    return i - 1'b1;
  endfunction

  // true when the set bits form a contiguous run from bit 0
  function automatic logic is_prefix(input rail_vec_t v);
    rail_vec_t s;
    s = v + 1'b1;
    return (s & v) == '0;
  endfunction
endpackage

// File: rtl/rail_seq_satcnt.sv
module rail_seq_satcnt #(
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] TOP = CW'(LIMIT);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!run)       cnt <= '0;
    else if (cnt != TOP) cnt <= cnt + 1'b1;
  end

  assign done = (cnt == TOP);

  // any break in the run condition restarts the interval (R1, R3, R5)
  assert_clear_on_break_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !done);
endmodule

// File: rtl/rail_seq_qual.sv
module rail_seq_qual
  import rail_seq_pkg::*;
#(
  parameter int LOCKOUT_CYC = 40,
  parameter int FILT_CYC    = 5
) (
  input  logic      clk,
  input  logic      rst_n,
  input  rail_vec_t uv_ok,
  input  logic      en_n,
  input  logic      sys_kill_in,
  output logic      all_ok,
  output logic      uv_bad,
  output logic      lock_done,
  output logic      kill_rise,
  output logic      sys_kill_out_n
);
  logic kill_q;
  logic filt_done;

  assign uv_bad = ~&uv_ok;
  assign all_ok = ~uv_bad & ~en_n & sys_kill_in;

  rail_seq_satcnt #(.LIMIT(LOCKOUT_CYC)) u_lock (
    .clk(clk), .rst_n(rst_n), .run(all_ok), .done(lock_done)
  );

  rail_seq_satcnt #(.LIMIT(FILT_CYC)) u_filt (
    .clk(clk), .rst_n(rst_n), .run(uv_bad), .done(filt_done)
  );

  assign sys_kill_out_n = ~filt_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) kill_q <= 1'b1;
    else        kill_q <= sys_kill_in;
  end

  assign kill_rise = sys_kill_in & ~kill_q;

  assert_lock_needs_qual_R1: assert property (@(posedge clk) disable iff (!rst_n)
    lock_done |-> $past(all_ok));

  assert_killout_after_fault_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_kill_out_n) |-> $past(uv_bad));

  assert_killout_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (uv_bad && !sys_kill_out_n) |=> !sys_kill_out_n);
endmodule

// File: rtl/rail_seq_fsm.sv
module rail_seq_fsm
  import rail_seq_pkg::*;
#(
  parameter int HOLD_CYC = 60
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      en_n,
  input  logic      sys_kill_in,
  input  logic      uv_bad,
  input  logic      all_ok,
  input  logic      lock_done,
  input  logic      kill_rise,
  input  rail_vec_t near_full,
  input  rail_vec_t full,
  input  rail_vec_t low_flag,
  output rail_vec_t gate_on,
  output logic      rst_out_n
);
  seq_state_e st;
  rail_idx_t  idx;
  rail_vec_t  gates;
  logic       hold_done;

  // named events for the assertions
  logic hard_off;
  logic start_req;

  assign hard_off  = ~sys_kill_in | uv_bad;
  assign start_req = lock_done | (kill_rise & all_ok);

  rail_seq_satcnt #(.LIMIT(HOLD_CYC)) u_hold (
    .clk(clk), .rst_n(rst_n), .run(st == ST_HOLD), .done(hold_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_OFF;
      idx   <= IDX_FIRST;
      gates <= '0;
    end else if (hard_off) begin
      st    <= ST_OFF;
      idx   <= IDX_FIRST;
      gates <= '0;
    end else begin
      case (st)
        ST_OFF: begin
          if (start_req) begin
            gates[IDX_FIRST] <= 1'b1;
            idx <= IDX_FIRST;
            st  <= ST_RAMP_UP;
          end
        end
        ST_RAMP_UP: begin
          if (en_n) begin
            st <= ST_RAMP_DN;
            idx <= IDX_LAST;
            gates[IDX_LAST] <= 1'b0;
          end else if (near_full[idx]) begin
            if (idx == IDX_LAST) begin
              st <= ST_WAIT_FULL;
            end else begin
              gates[idx_up(idx)] <= 1'b1;
              idx <= idx_up(idx);
            end
          end
        end
        ST_WAIT_FULL, ST_HOLD, ST_RUN: begin
          if (en_n) begin
            st <= ST_RAMP_DN;
            idx <= IDX_LAST;
            gates[IDX_LAST] <= 1'b0;
          end else if (st == ST_WAIT_FULL && full[IDX_LAST]) begin
            st <= ST_HOLD;
          end else if (st == ST_HOLD && hold_done) begin
            st <= ST_RUN;
          end
        end
        ST_RAMP_DN: begin
          if (low_flag[idx]) begin
            if (idx == IDX_FIRST) begin
              st <= ST_OFF;
            end else begin
              gates[idx_dn(idx)] <= 1'b0;
              idx <= idx_dn(idx);
            end
          end
        end
        default: st <= ST_OFF;
      endcase
    end
  end

  assign gate_on   = gates;
  assign rst_out_n = (st == ST_RUN);

  assert_kill_forces_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !sys_kill_in |=> (gate_on == '0 && !rst_out_n));

  assert_fault_forces_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    uv_bad |=> (gate_on == '0 && !rst_out_n));

  assert_prefix_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    is_prefix(gate_on));

  assert_reset_needs_all_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rst_out_n |-> (&gate_on));

  assert_disable_drops_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
    en_n |=> !rst_out_n);

  for (genvar k = 1; k < RAILS; k++) begin : g_up_chk
    assert_step_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_on[k]) |-> $past(near_full[k-1]));
  end

  for (genvar k = 0; k < RAILS - 1; k++) begin : g_dn_chk
    assert_step_dn_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(gate_on[k]) && !$past(hard_off)) |-> $past(low_flag[k+1]));
  end
endmodule

// File: rtl/rail_seq_top.sv
module rail_seq_top
  import rail_seq_pkg::*;
#(
  parameter int LOCKOUT_CYC = 40,
  parameter int HOLD_CYC    = 60,
  parameter int FILT_CYC    = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] uv_ok,
  input  logic       en_n,
  input  logic       sys_kill_in,
  input  logic [3:0] near_full,
  input  logic [3:0] full,
  input  logic [3:0] low_flag,
  output logic [3:0] gate_on,
  output logic       rst_out_n,
  output logic       sys_kill_out_n
);
  logic all_ok, uv_bad, lock_done, kill_rise;

  rail_seq_qual #(.LOCKOUT_CYC(LOCKOUT_CYC), .FILT_CYC(FILT_CYC)) u_qual (
    .clk(clk), .rst_n(rst_n), .uv_ok(uv_ok), .en_n(en_n),
    .sys_kill_in(sys_kill_in), .all_ok(all_ok), .uv_bad(uv_bad),
    .lock_done(lock_done), .kill_rise(kill_rise),
    .sys_kill_out_n(sys_kill_out_n)
  );

  rail_seq_fsm #(.HOLD_CYC(HOLD_CYC)) u_fsm (
    .clk(clk), .rst_n(rst_n), .en_n(en_n), .sys_kill_in(sys_kill_in),
    .uv_bad(uv_bad), .all_ok(all_ok), .lock_done(lock_done),
    .kill_rise(kill_rise), .near_full(near_full), .full(full),
    .low_flag(low_flag), .gate_on(gate_on), .rst_out_n(rst_out_n)
  );

  // R10: outputs at reset
  always_comb begin
    if (!rst_n) begin
      assert_reset_state_R10: assert (gate_on == 4'b0000 && !rst_out_n && sys_kill_out_n);
    end
  end
endmodule

// File: tb/rail_seq_top_tb_top.sv
module rail_seq_top_tb_top;
  localparam int L = 40;
  localparam int H = 60;
  localparam int F = 5;
  localparam int TOPLVL = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] uv_ok = 4'hF;
  logic en_n = 1'b1;
  logic kill_in = 1'b1;
  logic [3:0] near_full, full, low_flag;
  logic [3:0] gate_on;
  logic rst_out_n, kill_out_n;

  int n_cmp = 0;
  int n_bad = 0;
  int prefix_viol = 0;
  int lvl [4] = '{default: 0};

  always #5 clk = ~clk;

  rail_seq_top #(.LOCKOUT_CYC(L), .HOLD_CYC(H), .FILT_CYC(F)) dut_i (
    .clk(clk), .rst_n(rst_n), .uv_ok(uv_ok), .en_n(en_n),
    .sys_kill_in(kill_in), .near_full(near_full), .full(full),
    .low_flag(low_flag), .gate_on(gate_on), .rst_out_n(rst_out_n),
    .sys_kill_out_n(kill_out_n)
  );

  // rail level model: one step per cycle, updated away from the sampling edge
  always @(negedge clk) begin
    for (int i = 0; i < 4; i++) begin
      if (gate_on[i] && lvl[i] < TOPLVL) lvl[i] = lvl[i] + 1;
      else if (!gate_on[i] && lvl[i] > 0) lvl[i] = lvl[i] - 1;
    end
  end

  always_comb begin
    for (int i = 0; i < 4; i++) begin
      near_full[i] = (lvl[i] >= TOPLVL - 1);
      full[i]      = (lvl[i] == TOPLVL);
      low_flag[i]  = (lvl[i] <= 1);
    end
  end

  // R2 monitor: legal gate patterns only
  initial begin
    forever begin
      @(posedge clk); #3;
      if (rst_n && !(gate_on inside {4'b0000, 4'b0001, 4'b0011, 4'b0111, 4'b1111}))
        prefix_viol++;
    end
  end

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic chk(input logic ok, input string req, input string what,
                     input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_run();
    int n = 0;
    while (!rst_out_n && n < 1000) begin tick(); n++; end
    chk(rst_out_n && gate_on == 4'hF, "R3", "reached run with all gates", int'(gate_on), 15);
  endtask

  task automatic t_reset();
    ticks(3);
    chk(gate_on == 0 && !rst_out_n && kill_out_n, "R10", "reset outputs",
        int'({gate_on, rst_out_n, kill_out_n}), 1);
    rst_n = 1'b1;
    tick();
    chk(gate_on == 0 && !rst_out_n && kill_out_n, "R10", "after reset release",
        int'({gate_on, rst_out_n, kill_out_n}), 1);
  endtask

  task automatic t_lockout();
    en_n = 1'b0;
    ticks(L / 2);
    en_n = 1'b1;           // break the qualifying condition
    tick();
    en_n = 1'b0;
    ticks(L);
    chk(gate_on == 0, "R1", "gate A still off at lockout edge", int'(gate_on), 0);
    tick();
    chk(gate_on == 4'b0001, "R1", "gate A on after lockout", int'(gate_on), 1);
  endtask

  task automatic t_order_and_hold();
    int rise [4] = '{0, -1, -1, -1};
    int t = 0;
    int n = 0;
    while (!full[3] && t < 500) begin
      tick(); t++;
      for (int k = 1; k < 4; k++) if (gate_on[k] && rise[k] < 0) rise[k] = t;
    end
    chk(rise[1] > rise[0] && rise[2] > rise[1] && rise[3] > rise[2], "R2",
        "turn-on order A,B,C,D (D rise tick)", rise[3], rise[2] + 1);
    while (!rst_out_n && n < 1000) begin tick(); n++; end
    chk(n == H + 1, "R3", "reset release delay after D full", n, H + 1);
    chk(gate_on == 4'hF, "R3", "all gates on at release", int'(gate_on), 15);
  endtask

  task automatic t_disable();
    int fall [4] = '{-1, -1, -1, 0};
    int t = 0;
    logic ok_low = 1'b1;
    en_n = 1'b1;
    tick();
    chk(gate_on == 4'b0111 && !rst_out_n, "R8", "D off first and reset low",
        int'(gate_on), 7);
    ticks(3);
    chk(gate_on == 4'b0111, "R8", "C waits for D low", int'(gate_on), 7);
    while (gate_on != 0 && t < 500) begin
      tick(); t++;
      for (int k = 0; k < 3; k++) begin
        if (!gate_on[k] && fall[k] < 0) begin
          fall[k] = t;
          if (!low_flag[k+1]) ok_low = 1'b0;
        end
      end
    end
    chk(gate_on == 0, "R8", "all gates off", int'(gate_on), 0);
    chk(fall[2] < fall[1] && fall[1] < fall[0] && ok_low, "R8",
        "turn-off order D,C,B,A (A fall tick)", fall[0], fall[1] + 1);
  endtask

  task automatic t_fault();
    uv_ok = 4'b1011;
    tick();
    chk(gate_on == 0 && !rst_out_n, "R4", "fault drops all gates", int'(gate_on), 0);
    chk(kill_out_n, "R5", "kill out high before filter", int'(kill_out_n), 1);
    ticks(F - 2);
    chk(kill_out_n, "R5", "kill out high at filter-1", int'(kill_out_n), 1);
    tick();
    chk(!kill_out_n, "R5", "kill out low after filter", int'(kill_out_n), 0);
    uv_ok = 4'hF;
    tick();
    chk(kill_out_n, "R5", "kill out released", int'(kill_out_n), 1);
    ticks(L - 1);
    chk(gate_on == 0, "R9", "restart waits for lockout", int'(gate_on), 0);
    tick();
    chk(gate_on == 4'b0001, "R9", "automatic restart", int'(gate_on), 1);
    wait_run();
  endtask

  task automatic t_glitch();
    logic stayed = 1'b1;
    uv_ok = 4'b1110;
    for (int i = 0; i < F - 2; i++) begin
      tick();
      if (!kill_out_n) stayed = 1'b0;
    end
    chk(gate_on == 0, "R4", "short fault still drops gates", int'(gate_on), 0);
    uv_ok = 4'hF;
    tick();
    if (!kill_out_n) stayed = 1'b0;
    chk(stayed, "R5", "short fault never pulls kill line", 0, 1);
    ticks(L);
    chk(gate_on == 4'b0001, "R9", "restart after short fault", int'(gate_on), 1);
    wait_run();
  endtask

  task automatic t_kill();
    kill_in = 1'b0;
    tick();
    chk(gate_on == 0 && !rst_out_n, "R6", "kill input forces off", int'(gate_on), 0);
    ticks(15);
    chk(gate_on == 0, "R6", "gates stay off while kill low", int'(gate_on), 0);
    kill_in = 1'b1;
    tick();
    chk(gate_on == 4'b0001, "R7", "kill release skips lockout", int'(gate_on), 1);
    wait_run();
    // rise with enable inactive: nothing starts
    kill_in = 1'b0;
    en_n = 1'b1;
    ticks(15);
    kill_in = 1'b1;
    ticks(3);
    chk(gate_on == 0, "R7", "kill release with enable off", int'(gate_on), 0);
    en_n = 1'b0;
    ticks(L + 1);
    chk(gate_on == 4'b0001, "R1", "lockout start after kill release", int'(gate_on), 1);
    wait_run();
  endtask

  initial begin
    #(2_000_000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_lockout();
    t_order_and_hold();
    t_disable();
    en_n = 1'b0;
    ticks(L + 1);
    chk(gate_on == 4'b0001, "R1", "re-enable start", int'(gate_on), 1);
    wait_run();
    t_fault();
    t_glitch();
    t_kill();
    chk(prefix_viol == 0, "R2", "gate pattern violations", prefix_viol, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule